// File: doc/BRIEF.md
# Dual-Mode Packet Switch Input Port

This block is one input port of a small packet switch. Packets made of several phits arrive on a valid/ready stream. Each packet is forwarded to one of `NUM_OUT` output streams, and every output has its own valid and ready signals. The head phit names the destination in its low data bits, and a separate flag marks the final phit of the packet. All outputs share one data bus and one last-phit flag. Only the selected output raises its valid.

A mode input chooses how each packet is forwarded. In cut-through mode, the output is picked the moment the head phit is taken in. The rest of the packet then streams along that path, so the packet can span this port and the next stage at the same time. In store-and-forward mode, the port collects the whole packet in its buffer first. It picks the output only after the final phit has arrived, and only then lets any phit leave. The mode input is read once, when the head phit is accepted while the port is idle. Each packet therefore runs entirely in one mode.

`NUM_OUT` must be a power of two. The buffer depth `DEPTH` must be at least the largest packet length, which is 8 phits by default.

Top module: `pkt_route_port`

## Requirements
- R1: After reset, no out_valid bit is high and in_ready is high.
- R2: The destination is in_data of the head phit modulo NUM_OUT, which for the default of 4 is bits [1:0]. At most one out_valid bit is high at any time, and it is the bit of that destination.
- R3: In cut-through mode (mode_sf = 0 when the head is accepted), out_valid of the destination is high in the cycle right after the head phit is accepted.
- R4: All phits of a packet leave on the head's output, in arrival order and with their data unchanged. out_last is high only on the phit that was flagged last at the input.
- R5: In store-and-forward mode (mode_sf = 1 when the head is accepted), no out_valid bit is high until the last phit has been accepted. The destination's out_valid is high in the cycle right after that.
- R6: In store-and-forward mode, in_ready stays low from the acceptance of the last phit until that last phit has left. in_ready is also low whenever the buffer is full.
- R7: While the selected out_ready is low, out_valid, out_data and out_last hold their values. No phit is dropped or duplicated under any backpressure pattern.
- R8: A change of mode_sf after the head phit has been accepted has no effect on the packet in flight.
- R9: In cut-through mode, in_ready is low after the last phit is accepted until that phit has left. When the port is idle, in_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_sf | input | 1 | 1 = store-and-forward, 0 = cut-through; read at head acceptance |
| in_valid | input | 1 | Input phit valid |
| in_ready | output | 1 | Port can take a phit |
| in_data | input | DATA_W | Input phit payload; on the head phit, the low bits give the destination |
| in_last | input | 1 | Input phit is the last one of its packet |
| out_valid | output | NUM_OUT | Per-output phit valid, at most one bit high |
| out_ready | input | NUM_OUT | Per-output ready |
| out_data | output | DATA_W | Shared output phit payload |
| out_last | output | 1 | Output phit is the last one of its packet |

## Verification
A wrong route register appears within a cycle of the head as the wrong out_valid bit. The scoreboard then reports a port mismatch on the very first phit. A state machine stuck in the wrong mode shows up at the same point: in cut-through mode no valid appears one cycle after the head, and in store-and-forward mode a valid appears while the packet is still arriving. Buffer pointer faults appear later, as corrupted, missing or repeated phits in the scoreboard comparison or as items left over at the final drain check. A wrong ready or in-flight flag shows up as in_ready being high after the last phit, or the port staying blocked forever, which the watchdog catches.

// File: rtl/pkt_route_pkg.sv
package pkt_route_pkg;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_CUT  = 2'd1,
    PS_FILL = 2'd2,
    PS_SEND = 2'd3
  } port_state_e;

  // Destination index of a head word; nports must be a power of two.
  function automatic int unsigned pick_dest(input logic [31:0] word,
                                            input int unsigned nports);
    return int'(word) % nports;
  endfunction

endpackage

// File: rtl/pkt_fifo.sv
module pkt_fifo #(
  parameter int W     = 17,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] count;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign rdata = mem[rptr];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push && !full)  wptr <= bump(wptr);
      if (pop && !empty)  rptr <= bump(rptr);
      case ({push && !full, pop && !empty})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/pkt_out_demux.sv
module pkt_out_demux #(
  parameter int NUM_OUT = 4,
  parameter int SEL_W   = 2
) (
  input  logic               enable,
  input  logic [SEL_W-1:0]   sel,
  input  logic [NUM_OUT-1:0] out_ready,
  output logic [NUM_OUT-1:0] out_valid,
  output logic               fire
);
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_lane
    assign out_valid[g] = enable && (sel == SEL_W'(g));
  end
  assign fire = |(out_valid & out_ready);
endmodule

// File: rtl/pkt_route_port.sv
module pkt_route_port
  import pkt_route_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mode_sf,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DATA_W-1:0]  in_data,
  input  logic               in_last,
  output logic [NUM_OUT-1:0] out_valid,
  input  logic [NUM_OUT-1:0] out_ready,
  output logic [DATA_W-1:0]  out_data,
  output logic               out_last
);
  localparam int SEL_W = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1;
  localparam int FW    = DATA_W + 1;

  port_state_e      st;
  logic [SEL_W-1:0] route_q;
  logic             in_done;

  logic [FW-1:0] f_rdata;
  logic          f_empty, f_full;
  logic          fwd_en, out_fire;

  // named events for the checker
  logic st_idle, st_cut, st_fill, st_send;
  logic in_take, head_take, last_take, tail_leave;

  assign st_idle = (st == PS_IDLE);
  assign st_cut  = (st == PS_CUT);
  assign st_fill = (st == PS_FILL);
  assign st_send = (st == PS_SEND);

  function automatic logic [SEL_W-1:0] dest_of(input logic [DATA_W-1:0] d);
    logic [31:0] w;
    w = 32'(d);
    return SEL_W'(pick_dest(w, NUM_OUT));
  endfunction

  assign in_ready   = !f_full && (st_idle || st_fill || (st_cut && !in_done));
  assign in_take    = in_valid && in_ready;
  assign head_take  = in_take && st_idle;
  assign last_take  = in_take && in_last;
  assign fwd_en     = !f_empty && (st_cut || st_send);
  assign tail_leave = out_fire && f_rdata[DATA_W];

  assign out_data = f_rdata[DATA_W-1:0];
  assign out_last = f_rdata[DATA_W];

  pkt_fifo #(.W(FW), .DEPTH(DEPTH)) u_buf (
    .clk   (clk),
    .rst   (rst),
    .push  (in_take),
    .wdata ({in_last, in_data}),
    .pop   (out_fire),
    .rdata (f_rdata),
    .empty (f_empty),
    .full  (f_full)
  );

  pkt_out_demux #(.NUM_OUT(NUM_OUT), .SEL_W(SEL_W)) u_dmx (
    .enable    (fwd_en),
    .sel       (route_q),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .fire      (out_fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= PS_IDLE;
      route_q <= '0;
      in_done <= 1'b0;
    end else begin
      unique case (st)
        PS_IDLE: if (head_take) begin
          in_done <= in_last;
          if (!mode_sf) begin
            route_q <= dest_of(in_data);
            st      <= PS_CUT;
          end else if (in_last) begin
            route_q <= dest_of(in_data);
            st      <= PS_SEND;
          end else begin
            st      <= PS_FILL;
          end
        end
        PS_CUT: begin
          if (last_take) in_done <= 1'b1;
          if (tail_leave) begin
            in_done <= 1'b0;
            st      <= PS_IDLE;
          end
        end
        PS_FILL: if (last_take) begin
          // whole packet now held: decide from the stored head
          route_q <= dest_of(f_rdata[DATA_W-1:0]);
          in_done <= 1'b1;
          st      <= PS_SEND;
        end
        PS_SEND: if (tail_leave) begin
          in_done <= 1'b0;
          st      <= PS_IDLE;
        end
        default: st <= PS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pkt_route_port_chk.sv
module pkt_route_port_chk #(
  parameter int NUM_OUT = 4,
  parameter int DATA_W  = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               mode_sf,
  input logic               in_ready,
  input logic [NUM_OUT-1:0] out_valid,
  input logic [NUM_OUT-1:0] out_ready,
  input logic [DATA_W-1:0]  out_data,
  input logic               out_last,
  input logic               st_idle,
  input logic               st_cut,
  input logic               st_fill,
  input logic               st_send,
  input logic               head_take
);
  assert_onehot_valid_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(out_valid));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (|(out_valid & ~out_ready)) |=>
      ($stable(out_valid) && $stable(out_data) && $stable(out_last)));

  assert_cut_latency_R3: assert property (@(posedge clk) disable iff (rst)
    (head_take && !mode_sf) |=> (|out_valid));

  assert_fill_silent_R5: assert property (@(posedge clk) disable iff (rst)
    st_fill |-> (out_valid == '0));

  assert_send_blocks_R6: assert property (@(posedge clk) disable iff (rst)
    st_send |-> !in_ready);

  assert_mode_locked_R8: assert property (@(posedge clk) disable iff (rst)
    st_cut |=> (st_cut || st_idle));

  assert_idle_ready_R9: assert property (@(posedge clk) disable iff (rst)
    st_idle |-> in_ready);
endmodule

bind pkt_route_port pkt_route_port_chk #(.NUM_OUT(NUM_OUT), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mode_sf   (mode_sf),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last),
  .st_idle   (st_idle),
  .st_cut    (st_cut),
  .st_fill   (st_fill),
  .st_send   (st_send),
  .head_take (head_take)
);

// File: tb/pkt_route_port_test.sv
`timescale 1ns/1ps
module pkt_route_port_test;
  localparam int NO = 4;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode_sf = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic          in_last = 1'b0;
  logic [NO-1:0] out_valid;
  logic [NO-1:0] out_ready;
  logic [DW-1:0] out_data;
  logic          out_last;

  int tests = 0;
  int fails = 0;
  int bp    = 0;   // 0 all ready, 1 none ready, 2 toggling
  int cyc   = 0;
  logic [2+DW:0] expq [$];   // {port[1:0], last, data}

  always #10 clk = ~clk;   // 50 MHz

  pkt_route_port #(.NUM_OUT(NO), .DATA_W(DW), .DEPTH(8)) uut (
    .clk(clk), .rst(rst), .mode_sf(mode_sf),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // backpressure driver
  always @(negedge clk) begin
    cyc++;
    case (bp)
      0: out_ready <= '1;
      1: out_ready <= '0;
      default: out_ready <= (cyc % 3 == 0) ? '0 : '1;
    endcase
  end

  // monitor: pops and compares every phit that leaves
  initial begin
    forever begin
      @(negedge clk); #5;
      if (!rst && |(out_valid & out_ready)) begin
        int port = 0;
        for (int i = 0; i < NO; i++) if (out_valid[i]) port = i;
        check($countones(out_valid) == 1, "R2 onehot", int'(out_valid), 1);
        if (expq.size() == 0) begin
          check(1'b0, "R7 duplicate phit", int'(out_data), 0);
        end else begin
          logic [2+DW:0] e;
          e = expq.pop_front();
          check(port == int'(e[2+DW:1+DW]), "R2 port", port, int'(e[2+DW:1+DW]));
          check(out_data == e[DW-1:0], "R4 data", int'(out_data), int'(e[DW-1:0]));
          check(out_last == e[DW], "R4 last", int'(out_last), int'(e[DW]));
        end
      end
    end
  end

  // kind: 0 none, 1 cut latency, 2 store checks, 3 mode flip mid-packet, 4 ready-after-last
  task automatic send_pkt(input int dest, input int len, input int base, input int kind);
    for (int k = 0; k < len; k++) begin
      logic [DW-1:0] d;
      d = (k == 0) ? DW'((base << 2) | dest) : DW'(base * 17 + k * 5);
      expq.push_back({2'(dest), (k == len - 1), d});
      @(negedge clk);
      in_valid = 1'b1; in_data = d; in_last = (k == len - 1);
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
      @(posedge clk); #5;
      if (k == 0 && (kind == 1 || kind == 3))
        check(out_valid[dest] == 1'b1, "R3 cut-through valid after head", int'(out_valid), 1 << dest);
      if (k == 0 && kind == 3) mode_sf = 1'b1;
      if (kind == 2 && k < len - 1)
        check(out_valid == '0, "R5 no output while filling", int'(out_valid), 0);
      if (kind == 2 && k == len - 1) begin
        check(out_valid[dest] == 1'b1, "R5 output after last", int'(out_valid), 1 << dest);
        check(in_ready == 1'b0, "R6 ready low while holding", int'(in_ready), 0);
      end
      if (kind == 4 && k == len - 1)
        check(in_ready == 1'b0, "R9 ready low after last", int'(in_ready), 0);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while (expq.size() != 0 && n < 2000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    check(1'b0, "R7 watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #5;
    check(out_valid == '0, "R1 reset valid", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 reset ready", int'(in_ready), 1);

    // cut-through, several destinations and lengths
    mode_sf = 1'b0; bp = 0;
    send_pkt(2, 4, 1, 1);
    send_pkt(0, 8, 2, 1);
    send_pkt(3, 1, 3, 1);
    drain();

    // store-and-forward
    mode_sf = 1'b1;
    send_pkt(1, 8, 4, 2);
    send_pkt(3, 3, 5, 2);
    send_pkt(2, 1, 6, 2);
    drain();

    // backpressure in both modes
    bp = 2;
    mode_sf = 1'b0;
    send_pkt(3, 6, 7, 0);
    send_pkt(0, 5, 8, 0);
    mode_sf = 1'b1;
    send_pkt(1, 7, 9, 0);
    drain();
    bp = 0;

    // R8: mode flips to store after a cut-through head, packet stays cut-through
    mode_sf = 1'b0;
    send_pkt(1, 5, 10, 3);
    drain();
    // next packet picks up the new mode at its head
    send_pkt(2, 4, 11, 2);
    drain();

    // R9: stalled output in cut-through blocks input after last
    mode_sf = 1'b0; bp = 1;
    send_pkt(0, 3, 12, 4);
    #2;
    check(in_ready == 1'b0, "R9 still blocked while stalled", int'(in_ready), 0);
    check(out_valid[0] == 1'b1, "R7 held under stall", int'(out_valid), 1);
    bp = 0;
    drain();
    #5;
    check(in_ready == 1'b1, "R9 ready in idle", int'(in_ready), 1);

    check(expq.size() == 0, "R7 all phits delivered", expq.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule